// File: doc/BRIEF.md
# Queued-Duty Pulse-Width Modulator

This block produces a pulse-width modulated output whose duty value is fed through a short queue. Software programs a period and a clock divider, then writes duty values into the queue. The block counts out each period in divided clock ticks. At the start of every period it takes the next queued duty value into an active compare register. If the queue is empty, it keeps the previous compare value. The output is high from the start of the period until the count reaches the compare value.

A 32-bit register bus with a write strobe and a combinational read port gives access to four word registers:

| Offset | Register | Contents |
|--------|----------|----------|
| 0x00 | control | enable, software reset, divider, clock select, three stored run enables |
| 0x04 | status | queue occupancy |
| 0x0C | duty | write pushes into the queue; read returns the active compare value |
| 0x10 | period | period length |

A self-clearing software reset empties the queue and returns the control fields to their defaults.

Top module: `pwm_fifo_gen`

## Requirements
- R1: After reset, the control, status and duty registers read 0 and `pwm_out` is low.
- R2: Control bit 0 enables counting and the output. Control bits 15:4 hold a divider field N, and one period count step lasts N+1 clock cycles.
- R3: Control bits 17:16, 22, 23 and 24 are stored and read back unchanged. All other control bits except bit 0 read 0 when bit 3 is written 0.
- R4: One period lasts (P+2) count steps, where P is the value at offset 0x10. A P above 0xFFFE is treated as 0xFFFE.
- R5: A write to offset 0x0C pushes its low 16 bits into a 4-entry queue. Offset 0x04 bits 2:0 read the number of occupied entries, from 0 to 4.
- R6: A duty write while the queue holds 4 entries is dropped and leaves the occupancy at 4.
- R7: When counting starts, and at each period wrap, the oldest queue entry moves into the active compare register if the queue is non-empty. Otherwise the compare value is kept. A read of offset 0x0C returns the active compare value. Counting starts on the cycle after the enable bit is seen set.
- R8: `pwm_out` is high while the period count is below the compare value and low for the rest of the period. A compare value of 0 gives a constant low output.
- R9: Writing control with bit 3 set empties the queue, clears the control fields and clears the compare value. Bit 3 then reads 1 for exactly one cycle and 0 afterwards. The period register is kept.
- R10: While the enable bit is 0, `pwm_out` is low, the divider and period counts are held at zero, and the queue contents and occupancy are kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pwm_out | output | 1 | Modulated output |

## Verification
The bench builds the block with its defaults: a 4-entry queue and a 16-bit period count. With these values the full-queue drop and the reuse of the last entry are reached after five writes. The 16-bit width also brings the period clamp within reach: a single full-length period of 65536 steps, run at divider 0, shows where the wrap falls. Short periods with divider values 0 and 1 give exact high-time counts per period.

// File: rtl/pwm_fifo_pkg.sv
package pwm_fifo_pkg;

    localparam int PRE_W = 12;
    localparam int SEL_W = 2;

    localparam logic [4:0] OFS_CTRL   = 5'h00;
    localparam logic [4:0] OFS_STAT   = 5'h04;
    localparam logic [4:0] OFS_DUTY   = 5'h0C;
    localparam logic [4:0] OFS_PERIOD = 5'h10;

    localparam int BIT_EN   = 0;
    localparam int BIT_SWR  = 3;
    localparam int PRE_LSB  = 4;
    localparam int SEL_LSB  = 16;
    localparam int BIT_DBG  = 22;
    localparam int BIT_WAIT = 23;
    localparam int BIT_DOZE = 24;

    typedef struct packed {
        logic             keep_doze;
        logic             keep_wait;
        logic             keep_dbg;
        logic [SEL_W-1:0] clk_sel;
        logic [PRE_W-1:0] presc;
        logic             swr;
        logic             en;
    } ctrl_t;

    function automatic ctrl_t ctrl_from_word(input logic [31:0] w);
        ctrl_t c;
        c.en        = w[BIT_EN];
        c.swr       = 1'b0;
        c.presc     = w[PRE_LSB +: PRE_W];
        c.clk_sel   = w[SEL_LSB +: SEL_W];
        c.keep_dbg  = w[BIT_DBG];
        c.keep_wait = w[BIT_WAIT];
        c.keep_doze = w[BIT_DOZE];
        return c;
    endfunction

    function automatic logic [31:0] ctrl_to_word(input ctrl_t c);
        logic [31:0] w;
        w = '0;
        w[BIT_EN]            = c.en;
        w[BIT_SWR]           = c.swr;
        w[PRE_LSB +: PRE_W]  = c.presc;
        w[SEL_LSB +: SEL_W]  = c.clk_sel;
        w[BIT_DBG]           = c.keep_dbg;
        w[BIT_WAIT]          = c.keep_wait;
        w[BIT_DOZE]          = c.keep_doze;
        return w;
    endfunction

endpackage

// File: rtl/pwm_duty_fifo.sv
module pwm_duty_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       push,
    input  logic [W-1:0]               push_data,
    input  logic                       pop,
    output logic [W-1:0]               pop_data,
    output logic                       empty,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           rd;
        logic [PW-1:0]           wr;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     take_in, give_out;

    always_comb begin
        st_d     = st_q;
        take_in  = push && (st_q.cnt < FULL_CNT);
        give_out = pop && (st_q.cnt != '0);
        if (flush) begin
            st_d.rd  = '0;
            st_d.wr  = '0;
            st_d.cnt = '0;
        end else begin
            if (take_in) begin
                st_d.mem[st_q.wr] = push_data;
                st_d.wr = (st_q.wr == LAST_IDX) ? '0 : st_q.wr + 1'b1;
            end
            if (give_out) begin
                st_d.rd = (st_q.rd == LAST_IDX) ? '0 : st_q.rd + 1'b1;
            end
            case ({take_in, give_out})
                2'b10:   st_d.cnt = st_q.cnt + 1'b1;
                2'b01:   st_d.cnt = st_q.cnt - 1'b1;
                default: st_d.cnt = st_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pop_data = st_q.mem[st_q.rd];
    assign empty    = (st_q.cnt == '0);
    assign count    = st_q.cnt;

endmodule

// File: rtl/pwm_period_engine.sv
module pwm_period_engine #(
    parameter int CNT_W = 16,
    parameter int PRE_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             clear,
    input  logic [PRE_W-1:0] presc,
    input  logic [CNT_W-1:0] period_last,
    input  logic             q_empty,
    input  logic [CNT_W-1:0] q_data,
    output logic             q_pop,
    output logic [CNT_W-1:0] cmp,
    output logic             level
);
    typedef struct packed {
        logic             run;
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] cmp;
    } eng_st_t;

    eng_st_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        q_pop = 1'b0;
        if (clear) begin
            st_d = '0;
        end else if (!enable) begin
            st_d.run = 1'b0;
            st_d.pre = '0;
            st_d.per = '0;
        end else if (!st_q.run) begin
            st_d.run = 1'b1;
            st_d.pre = '0;
            st_d.per = '0;
            if (!q_empty) begin
                q_pop    = 1'b1;
                st_d.cmp = q_data;
            end
        end else if (st_q.pre == presc) begin
            st_d.pre = '0;
            if (st_q.per == period_last) begin
                st_d.per = '0;
                if (!q_empty) begin
                    q_pop    = 1'b1;
                    st_d.cmp = q_data;
                end
            end else begin
                st_d.per = st_q.per + 1'b1;
            end
        end else begin
            st_d.pre = st_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmp   = st_q.cmp;
    assign level = st_q.run && enable && (st_q.per < st_q.cmp);

endmodule

// File: rtl/pwm_fifo_gen.sv
module pwm_fifo_gen
    import pwm_fifo_pkg::*;
#(
    parameter int FIFO_DEPTH = 4,
    parameter int CNT_W      = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_we,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        pwm_out
);
    localparam int CW = $clog2(FIFO_DEPTH + 1);
    localparam logic [CNT_W-1:0] PER_MAX = {{(CNT_W-1){1'b1}}, 1'b0};

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] period;
    } regs_t;

    regs_t            regs_d, regs_q;
    logic             swr_req;
    logic             duty_push;
    logic             ctrl_en;
    logic             ctrl_swr;
    logic [CNT_W-1:0] period_eff;
    logic [CNT_W-1:0] period_last;
    logic             eng_pop;
    logic             fifo_empty;
    logic [CNT_W-1:0] fifo_head;
    logic [CW-1:0]    fifo_cnt;
    logic [CNT_W-1:0] cmp_val;

    always_comb begin
        regs_d          = regs_q;
        regs_d.ctrl.swr = 1'b0;
        swr_req         = 1'b0;
        duty_push       = 1'b0;
        if (bus_we) begin
            case (bus_addr)
                OFS_CTRL: begin
                    if (bus_wdata[BIT_SWR]) begin
                        swr_req         = 1'b1;
                        regs_d.ctrl     = '0;
                        regs_d.ctrl.swr = 1'b1;
                    end else begin
                        regs_d.ctrl = ctrl_from_word(bus_wdata);
                    end
                end
                OFS_PERIOD: regs_d.period = bus_wdata[CNT_W-1:0];
                OFS_DUTY:   duty_push = 1'b1;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign ctrl_en     = regs_q.ctrl.en;
    assign ctrl_swr    = regs_q.ctrl.swr;
    assign period_eff  = (regs_q.period > PER_MAX) ? PER_MAX : regs_q.period;
    assign period_last = period_eff + 1'b1;

    pwm_duty_fifo #(
        .DEPTH (FIFO_DEPTH),
        .W     (CNT_W)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (swr_req),
        .push      (duty_push),
        .push_data (bus_wdata[CNT_W-1:0]),
        .pop       (eng_pop),
        .pop_data  (fifo_head),
        .empty     (fifo_empty),
        .count     (fifo_cnt)
    );

    pwm_period_engine #(
        .CNT_W (CNT_W),
        .PRE_W (PRE_W)
    ) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (ctrl_en),
        .clear       (swr_req),
        .presc       (regs_q.ctrl.presc),
        .period_last (period_last),
        .q_empty     (fifo_empty),
        .q_data      (fifo_head),
        .q_pop       (eng_pop),
        .cmp         (cmp_val),
        .level       (pwm_out)
    );

    always_comb begin
        case (bus_addr)
            OFS_CTRL:   bus_rdata = ctrl_to_word(regs_q.ctrl);
            OFS_STAT:   bus_rdata = 32'(fifo_cnt);
            OFS_DUTY:   bus_rdata = 32'(cmp_val);
            OFS_PERIOD: bus_rdata = 32'(regs_q.period);
            default:    bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/pwm_fifo_gen_chk.sv
module pwm_fifo_gen_chk #(
    parameter int FIFO_DEPTH = 4,
    parameter int CNT_W      = 16
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            pwm_out,
    input logic                            en,
    input logic                            swr,
    input logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_cnt,
    input logic                            fifo_pop,
    input logic                            fifo_flush,
    input logic [CNT_W-1:0]                cmp
);
    localparam int CW = $clog2(FIFO_DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(FIFO_DEPTH);

    // R5
    occ_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= FULL_CNT);

    // R6
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_cnt == FULL_CNT && !fifo_pop && !fifo_flush) |=> (fifo_cnt == FULL_CNT));

    // R9
    swr_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swr |=> !swr);

    // R9
    swr_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swr |-> (fifo_cnt == '0 && cmp == '0 && !en));

    // R10
    disabled_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !pwm_out);

    // R8
    zero_cmp_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp == '0) |-> !pwm_out);

endmodule

bind pwm_fifo_gen pwm_fifo_gen_chk #(
    .FIFO_DEPTH (FIFO_DEPTH),
    .CNT_W      (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwm_out    (pwm_out),
    .en         (ctrl_en),
    .swr        (ctrl_swr),
    .fifo_cnt   (fifo_cnt),
    .fifo_pop   (eng_pop),
    .fifo_flush (swr_req),
    .cmp        (cmp_val)
);

// File: tb/pwm_fifo_gen_tb.sv
`timescale 1ns/100ps
module pwm_fifo_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = 5'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pwm_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pwm_fifo_gen u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    // peek at a register within the current low clock phase
    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.1;
        d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        @(negedge clk);
        rd(5'h00, v); chk("R1", "ctrl after reset", v, 32'h0);
        rd(5'h04, v); chk("R1", "status after reset", v, 32'h0);
        rd(5'h0C, v); chk("R1", "duty after reset", v, 32'h0);
        chk("R1", "output after reset", 32'(pwm_out), 32'h0);
    endtask

    task automatic t_fields;
        logic [31:0] v;
        wr(5'h00, 32'hFFFF_FFF6);
        rd(5'h00, v); chk("R3", "stored control fields", v, 32'h01C3_FFF0);
        wr(5'h00, 32'h01C2_ABC0);
        rd(5'h00, v); chk("R3", "control readback", v, 32'h01C2_ABC0);
        wr(5'h00, 32'h0);
    endtask

    task automatic t_queue_run;
        logic [31:0] v;
        int exp_hi [5] = '{4, 10, 14, 16, 16};
        wr(5'h10, 32'd6);
        wr(5'h0C, 32'd2);
        wr(5'h0C, 32'd5);
        wr(5'h0C, 32'd7);
        rd(5'h04, v); chk("R5", "occupancy after three writes", v, 32'd3);
        wr(5'h0C, 32'd9);
        wr(5'h0C, 32'd11);
        rd(5'h04, v); chk("R6", "occupancy after write to full queue", v, 32'd4);
        rd(5'h0C, v); chk("R7", "compare before enable", v, 32'd0);
        wr(5'h00, 32'h11);
        @(posedge clk);
        for (int p = 0; p < 5; p++) begin
            int hi = 0;
            logic first_lvl = 1'b0;
            logic last_lvl = 1'b0;
            for (int c = 0; c < 16; c++) begin
                @(negedge clk);
                if (pwm_out) hi++;
                if (c == 0) first_lvl = pwm_out;
                if (c == 15) last_lvl = pwm_out;
            end
            chk("R2", $sformatf("high cycles in period %0d", p), 32'(hi), 32'(exp_hi[p]));
            if (p == 0) begin
                chk("R8", "high at period start", 32'(first_lvl), 32'h1);
                chk("R8", "low at period end", 32'(last_lvl), 32'h0);
            end
        end
        rd(5'h0C, v); chk("R7", "active compare reused", v, 32'd9);
        rd(5'h04, v); chk("R7", "queue drained", v, 32'd0);
        wr(5'h00, 32'h0);
        chk("R10", "output low after disable", 32'(pwm_out), 32'h0);
    endtask

    task automatic t_zero_cmp;
        int hi = 0;
        wr(5'h10, 32'd2);
        wr(5'h0C, 32'd0);
        wr(5'h00, 32'h1);
        @(posedge clk);
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            if (pwm_out) hi++;
        end
        chk("R8", "zero compare high cycles", 32'(hi), 32'd0);
        wr(5'h00, 32'h0);
    endtask

    task automatic t_hold_and_clamp;
        logic [31:0] v;
        logic s0 = 1'b0, s8 = 1'b0, s9 = 1'b1, s_end = 1'b1, s_wrap = 1'b0;
        wr(5'h10, 32'hFFFF);
        wr(5'h0C, 32'd5);
        wr(5'h00, 32'h1);
        repeat (3) @(negedge clk);
        wr(5'h0C, 32'd9);
        rd(5'h04, v); chk("R5", "occupancy while running", v, 32'd1);
        wr(5'h00, 32'h0);
        chk("R10", "output low while disabled", 32'(pwm_out), 32'h0);
        repeat (4) @(negedge clk);
        rd(5'h04, v); chk("R10", "queue kept while disabled", v, 32'd1);
        wr(5'h00, 32'h1);
        @(posedge clk);
        for (int i = 0; i <= 65536; i++) begin
            @(negedge clk);
            if (i == 0) s0 = pwm_out;
            if (i == 8) s8 = pwm_out;
            if (i == 9) s9 = pwm_out;
            if (i == 65535) s_end = pwm_out;
            if (i == 65536) s_wrap = pwm_out;
        end
        chk("R10", "restart high at first step", 32'(s0), 32'h1);
        chk("R10", "high at step 8 after restart", 32'(s8), 32'h1);
        chk("R8", "low at step 9 for compare 9", 32'(s9), 32'h0);
        chk("R4", "low at last step of clamped period", 32'(s_end), 32'h0);
        chk("R4", "new period after 0xFFFE+2 steps", 32'(s_wrap), 32'h1);
        rd(5'h0C, v); chk("R7", "compare from queued entry", v, 32'd9);
    endtask

    task automatic t_soft_reset;
        logic [31:0] v;
        wr(5'h0C, 32'd3);
        wr(5'h0C, 32'd4);
        wr(5'h00, 32'h0000_0059);
        rd(5'h00, v); chk("R9", "reset bit visible", v, 32'h8);
        rd(5'h04, v); chk("R9", "queue flushed", v, 32'd0);
        rd(5'h0C, v); chk("R9", "compare cleared", v, 32'd0);
        chk("R9", "output low", 32'(pwm_out), 32'h0);
        @(negedge clk);
        rd(5'h00, v); chk("R9", "reset bit self-cleared", v, 32'h0);
        rd(5'h10, v); chk("R9", "period kept", v, 32'hFFFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fields();
        t_queue_run();
        t_zero_cmp();
        t_hold_and_clamp();
        t_soft_reset();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule